// File: doc/BRIEF.md
# Display Power-Up Sequencer

This block brings an attached display module up and takes it down in a fixed order. It drives two lines: a panel reset line and a supply-enable line. It also drives a simple register-write master that programs the module's control registers. Four commands arrive as a one-cycle strobe with a 2-bit operation code: prepare, enable, disable and unprepare.

Prepare runs the power-up sequence. Reset is held while the supplies come up. After a settle delay, reset is released. After a second delay, a fixed list of initialisation writes is issued. That list starts with a global soft reset, then the voltage trims, then the gamma trims, and ends with polarity, interface control and entry mode. Enable and disable each do one write to the power-control register, moving the module between run and standby. Unprepare removes the supplies.

Both settle delays are parameters, counted in clock cycles. The configuration bytes written during initialisation are static inputs. A voltage trim that holds 0xFF is not written at all, so the module keeps its own default.

Top module: `disp_pwr_seq`

## Requirements
- R1: Command codes are 0 = prepare, 1 = enable, 2 = disable, 3 = unprepare. Prepare is accepted only when the block is off. `panel_rst` is already 1 in the cycle before `pwr_en` rises and stays 1 while it rises.
- R2: `pwr_en` stays high with `panel_rst` held at 1 for exactly SUP_WAIT_CYC cycles before `panel_rst` drops to 0.
- R3: No write request appears until at least RST_WAIT_CYC cycles after `panel_rst` drops. The first write is address 0x04 with data 0x00.
- R4: After that first write, the initialisation writes go out in this order: 0x03 (`cfg_vreg`), 0x01 (`cfg_vamp`), 0x02 (`cfg_vhigh`), then 0x10 up to 0x10+N_GAMMA-1 carrying `cfg_gamma` byte i (bits 8i+7..8i) at 0x10+i, then 0x0A (`cfg_pol`), 0x0B (`cfg_ifctl`) and 0x06 (`cfg_entry`).
- R5: Each of the three voltage writes (0x03, 0x01, 0x02) is skipped when its configuration byte is 0xFF. The other writes in the list are unaffected.
- R6: `wr_req` stays high with stable `wr_addr` and `wr_data` until a cycle in which `wr_done` is high. It is low in the next cycle.
- R7: Enable, when prepared and in standby, writes 0xEF to address 0x07 and enters run. Disable, when in run, writes 0xEE to address 0x07 and returns to standby.
- R8: Unprepare, when prepared (standby or run), clears `pwr_en` with no register write and leaves `panel_rst` unchanged.
- R9: A write that completes with `wr_err` high during initialisation clears `pwr_en`, stops the list and returns the block to off. An error on an enable or disable write leaves the state as it was. Either error sets `err_flag`, and the next accepted prepare clears it.
- R10: A command not valid in the current state has no effect on the outputs. This includes any command during a sequence or a write. Such a command sets `bad_cmd`, which stays set until reset.
- R11: After reset, `panel_rst` = 1, `pwr_en` = 0, `wr_req` = 0, `err_flag` = 0 and `bad_cmd` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 2 | Command code (0 prepare, 1 enable, 2 disable, 3 unprepare) |
| cfg_vreg | input | 8 | Regulator trim, written to 0x03; 0xFF skips the write |
| cfg_vamp | input | 8 | Swing-amplitude trim, written to 0x01; 0xFF skips the write |
| cfg_vhigh | input | 8 | High-level trim, written to 0x02; 0xFF skips the write |
| cfg_gamma | input | 8*N_GAMMA | Gamma bytes; byte i is written to 0x10+i |
| cfg_pol | input | 8 | Polarity byte, written to 0x0A |
| cfg_ifctl | input | 8 | Interface-control byte, written to 0x0B |
| cfg_entry | input | 8 | Entry-mode byte, written to 0x06 |
| panel_rst | output | 1 | Panel reset, 1 = asserted |
| pwr_en | output | 1 | Supply enable |
| wr_req | output | 1 | Register-write request |
| wr_addr | output | 8 | Register address |
| wr_data | output | 8 | Register data |
| wr_done | input | 1 | Write accepted, sampled while `wr_req` is high |
| wr_err | input | 1 | Write failed, valid together with `wr_done` |
| err_flag | output | 1 | Sticky write-error flag |
| bad_cmd | output | 1 | Sticky illegal-command flag |

## Verification
The initialisation list is tried with three kinds of configuration: every voltage trim present, every voltage trim at 0xFF, and random mixes. Comparing these separates a wrong skip decision from a wrong write order or a wrong gamma byte position. The write port answers after a random latency, which shows the request holds its address and data while waiting. The two delays are measured on the reset and supply pins. An error is injected partway through the list and again on an enable write; this tells an aborted bring-up from a state that is kept. Commands are sent while off, while in standby and while a sequence is running, which shows each illegal command is ignored.

// File: rtl/disp_seq_pkg.sv
package disp_seq_pkg;

  localparam int unsigned REG_AW = 8;
  localparam int unsigned REG_DW = 8;

  typedef enum logic [3:0] {
    S_OFF      = 4'd0,
    S_RST_HOLD = 4'd1,
    S_SUP_WAIT = 4'd2,
    S_RST_WAIT = 4'd3,
    S_INIT     = 4'd4,
    S_READY    = 4'd5,
    S_EN_WR    = 4'd6,
    S_RUN      = 4'd7,
    S_DIS_WR   = 4'd8
  } seq_state_t;

  typedef enum logic [1:0] {
    CMD_PREPARE   = 2'd0,
    CMD_ENABLE    = 2'd1,
    CMD_DISABLE   = 2'd2,
    CMD_UNPREPARE = 2'd3
  } seq_cmd_t;

  localparam logic [REG_AW-1:0] A_GRESET = 8'h04;
  localparam logic [REG_AW-1:0] A_VREG   = 8'h03;
  localparam logic [REG_AW-1:0] A_VAMP   = 8'h01;
  localparam logic [REG_AW-1:0] A_VHIGH  = 8'h02;
  localparam logic [REG_AW-1:0] A_GAMMA0 = 8'h10;
  localparam logic [REG_AW-1:0] A_POL    = 8'h0A;
  localparam logic [REG_AW-1:0] A_IFCTL  = 8'h0B;
  localparam logic [REG_AW-1:0] A_ENTRY  = 8'h06;
  localparam logic [REG_AW-1:0] A_PWRCTL = 8'h07;

  localparam logic [REG_DW-1:0] D_GRESET = 8'h00;
  localparam logic [REG_DW-1:0] D_RUN    = 8'hEF;
  localparam logic [REG_DW-1:0] D_STBY   = 8'hEE;
  localparam logic [REG_DW-1:0] D_KEEP   = 8'hFF;

endpackage

// File: rtl/disp_seq_timer.sv
module disp_seq_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign zero   = (cnt_q == '0);
  assign cnt_en = load | ~zero;

  always_comb begin
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/disp_seq_steps.sv
module disp_seq_steps
  import disp_seq_pkg::*;
#(
  parameter int unsigned N_GAMMA = 8,
  parameter int unsigned SW      = 4
) (
  input  logic [SW-1:0]           step,
  input  logic [REG_DW-1:0]       cfg_vreg,
  input  logic [REG_DW-1:0]       cfg_vamp,
  input  logic [REG_DW-1:0]       cfg_vhigh,
  input  logic [REG_DW*N_GAMMA-1:0] cfg_gamma,
  input  logic [REG_DW-1:0]       cfg_pol,
  input  logic [REG_DW-1:0]       cfg_ifctl,
  input  logic [REG_DW-1:0]       cfg_entry,
  output logic [REG_AW-1:0]       addr,
  output logic [REG_DW-1:0]       data,
  output logic                    skip
);

  localparam int unsigned GBASE = 4;
  localparam int unsigned TAIL  = GBASE + N_GAMMA;

  logic [REG_DW-1:0] gbyte [N_GAMMA];
  logic [N_GAMMA-1:0] ghit;

  for (genvar gi = 0; gi < N_GAMMA; gi++) begin : g_gamma
    assign gbyte[gi] = cfg_gamma[REG_DW*gi +: REG_DW];
    assign ghit[gi]  = (step == SW'(GBASE + gi));
  end

  always_comb begin
    addr = A_GRESET;
    data = D_GRESET;
    skip = 1'b0;
    if (step == SW'(1)) begin
      addr = A_VREG;  data = cfg_vreg;  skip = (cfg_vreg == D_KEEP);
    end else if (step == SW'(2)) begin
      addr = A_VAMP;  data = cfg_vamp;  skip = (cfg_vamp == D_KEEP);
    end else if (step == SW'(3)) begin
      addr = A_VHIGH; data = cfg_vhigh; skip = (cfg_vhigh == D_KEEP);
    end else if (step == SW'(TAIL)) begin
      addr = A_POL;   data = cfg_pol;
    end else if (step == SW'(TAIL + 1)) begin
      addr = A_IFCTL; data = cfg_ifctl;
    end else if (step == SW'(TAIL + 2)) begin
      addr = A_ENTRY; data = cfg_entry;
    end
    for (int i = 0; i < int'(N_GAMMA); i++) begin
      if (ghit[i]) begin
        addr = A_GAMMA0 + REG_AW'(i);
        data = gbyte[i];
      end
    end
  end

endmodule

// File: rtl/disp_seq_wport.sv
module disp_seq_wport
  import disp_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [REG_DW-1:0] data_i,
  input  logic              wr_done,
  input  logic              wr_err,
  output logic              wr_req,
  output logic [REG_AW-1:0] wr_addr,
  output logic [REG_DW-1:0] wr_data,
  output logic              fin,
  output logic              fin_err
);

  logic req_d;

  assign fin     = wr_req & wr_done;
  assign fin_err = fin & wr_err;

  always_comb begin
    req_d = wr_req;
    if (issue)    req_d = 1'b1;
    else if (fin) req_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_req <= 1'b0;
    else        wr_req <= req_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_addr <= '0;
      wr_data <= '0;
    end else if (issue) begin
      wr_addr <= addr_i;
      wr_data <= data_i;
    end
  end

endmodule

// File: rtl/disp_pwr_seq.sv
module disp_pwr_seq
  import disp_seq_pkg::*;
#(
  parameter int unsigned SUP_WAIT_CYC = 2500000,
  parameter int unsigned RST_WAIT_CYC = 1250000,
  parameter int unsigned N_GAMMA      = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_valid,
  input  logic [1:0]                cmd_op,
  input  logic [REG_DW-1:0]         cfg_vreg,
  input  logic [REG_DW-1:0]         cfg_vamp,
  input  logic [REG_DW-1:0]         cfg_vhigh,
  input  logic [REG_DW*N_GAMMA-1:0] cfg_gamma,
  input  logic [REG_DW-1:0]         cfg_pol,
  input  logic [REG_DW-1:0]         cfg_ifctl,
  input  logic [REG_DW-1:0]         cfg_entry,
  output logic                      panel_rst,
  output logic                      pwr_en,
  output logic                      wr_req,
  output logic [REG_AW-1:0]         wr_addr,
  output logic [REG_DW-1:0]         wr_data,
  input  logic                      wr_done,
  input  logic                      wr_err,
  output logic                      err_flag,
  output logic                      bad_cmd
);

  localparam int unsigned N_STEPS = 4 + N_GAMMA + 3;
  localparam int unsigned SW      = $clog2(N_STEPS);
  localparam int unsigned MAXD    = (SUP_WAIT_CYC > RST_WAIT_CYC) ? SUP_WAIT_CYC : RST_WAIT_CYC;
  localparam int unsigned CW      = $clog2(MAXD + 1);
  localparam logic [SW-1:0] LAST  = SW'(N_STEPS - 1);

  seq_state_t state_q, state_d;
  logic [SW-1:0] step_q;
  logic          step_clr, step_inc;
  logic          rst_set, rst_clr, pwr_set, pwr_clr;
  logic          err_set, err_clr, bad_set, cmd_taken;
  logic          tmr_load, tmr_zero;
  logic [CW-1:0] tmr_val;
  logic          issue, fin, fin_err;
  logic [REG_AW-1:0] iss_addr, st_addr;
  logic [REG_DW-1:0] iss_data, st_data;
  logic          st_skip;
  logic          is_last;

  disp_seq_timer #(.CW(CW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  disp_seq_steps #(.N_GAMMA(N_GAMMA), .SW(SW)) u_steps (
    .step      (step_q),
    .cfg_vreg  (cfg_vreg),
    .cfg_vamp  (cfg_vamp),
    .cfg_vhigh (cfg_vhigh),
    .cfg_gamma (cfg_gamma),
    .cfg_pol   (cfg_pol),
    .cfg_ifctl (cfg_ifctl),
    .cfg_entry (cfg_entry),
    .addr      (st_addr),
    .data      (st_data),
    .skip      (st_skip)
  );

  disp_seq_wport u_wport (
    .clk     (clk),
    .rst_n   (rst_n),
    .issue   (issue),
    .addr_i  (iss_addr),
    .data_i  (iss_data),
    .wr_done (wr_done),
    .wr_err  (wr_err),
    .wr_req  (wr_req),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .fin     (fin),
    .fin_err (fin_err)
  );

  assign is_last = (step_q == LAST);

  always_comb begin
    state_d   = state_q;
    step_clr  = 1'b0;
    step_inc  = 1'b0;
    rst_set   = 1'b0;
    rst_clr   = 1'b0;
    pwr_set   = 1'b0;
    pwr_clr   = 1'b0;
    err_set   = 1'b0;
    err_clr   = 1'b0;
    cmd_taken = 1'b0;
    tmr_load  = 1'b0;
    tmr_val   = CW'(SUP_WAIT_CYC - 1);
    issue     = 1'b0;
    iss_addr  = st_addr;
    iss_data  = st_data;

    unique case (state_q)
      S_OFF: begin
        if (cmd_valid && cmd_op == CMD_PREPARE) begin
          cmd_taken = 1'b1;
          rst_set   = 1'b1;
          err_clr   = 1'b1;
          state_d   = S_RST_HOLD;
        end
      end
      S_RST_HOLD: begin
        pwr_set  = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = CW'(SUP_WAIT_CYC - 1);
        state_d  = S_SUP_WAIT;
      end
      S_SUP_WAIT: begin
        if (tmr_zero) begin
          rst_clr  = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = CW'(RST_WAIT_CYC - 1);
          state_d  = S_RST_WAIT;
        end
      end
      S_RST_WAIT: begin
        if (tmr_zero) begin
          step_clr = 1'b1;
          state_d  = S_INIT;
        end
      end
      S_INIT: begin
        if (!wr_req) begin
          if (st_skip) begin
            if (is_last) state_d = S_READY;
            else         step_inc = 1'b1;
          end else begin
            issue = 1'b1;
          end
        end else if (fin) begin
          if (fin_err) begin
            pwr_clr = 1'b1;
            err_set = 1'b1;
            state_d = S_OFF;
          end else if (is_last) begin
            state_d = S_READY;
          end else begin
            step_inc = 1'b1;
          end
        end
      end
      S_READY: begin
        if (cmd_valid && cmd_op == CMD_ENABLE) begin
          cmd_taken = 1'b1;
          issue     = 1'b1;
          iss_addr  = A_PWRCTL;
          iss_data  = D_RUN;
          state_d   = S_EN_WR;
        end else if (cmd_valid && cmd_op == CMD_UNPREPARE) begin
          cmd_taken = 1'b1;
          pwr_clr   = 1'b1;
          state_d   = S_OFF;
        end
      end
      S_EN_WR: begin
        if (fin) begin
          if (fin_err) begin
            err_set = 1'b1;
            state_d = S_READY;
          end else begin
            state_d = S_RUN;
          end
        end
      end
      S_RUN: begin
        if (cmd_valid && cmd_op == CMD_DISABLE) begin
          cmd_taken = 1'b1;
          issue     = 1'b1;
          iss_addr  = A_PWRCTL;
          iss_data  = D_STBY;
          state_d   = S_DIS_WR;
        end else if (cmd_valid && cmd_op == CMD_UNPREPARE) begin
          cmd_taken = 1'b1;
          pwr_clr   = 1'b1;
          state_d   = S_OFF;
        end
      end
      S_DIS_WR: begin
        if (fin) begin
          if (fin_err) begin
            err_set = 1'b1;
            state_d = S_RUN;
          end else begin
            state_d = S_READY;
          end
        end
      end
      default: state_d = S_OFF;
    endcase

    bad_set = cmd_valid & ~cmd_taken;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_OFF;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   step_q <= '0;
    else if (step_clr | step_inc) step_q <= step_clr ? '0 : step_q + SW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 panel_rst <= 1'b1;
    else if (rst_set | rst_clr) panel_rst <= rst_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 pwr_en <= 1'b0;
    else if (pwr_set | pwr_clr) pwr_en <= pwr_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 err_flag <= 1'b0;
    else if (err_set | err_clr) err_flag <= err_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bad_cmd <= 1'b0;
    else if (bad_set) bad_cmd <= 1'b1;
  end

endmodule

// File: rtl/disp_pwr_seq_chk.sv
module disp_pwr_seq_chk
  import disp_seq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              panel_rst,
  input logic              pwr_en,
  input logic              wr_req,
  input logic [REG_AW-1:0] wr_addr,
  input logic [REG_DW-1:0] wr_data,
  input logic              wr_done,
  input logic              bad_cmd
);

  p_rst_before_pwr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_en) |-> (panel_rst && $past(panel_rst)))
    else $error("reset not held when supplies came on");

  p_no_early_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> (pwr_en && !panel_rst))
    else $error("write request while unpowered or in reset");

  p_trim_skip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && (wr_addr == A_VREG || wr_addr == A_VAMP || wr_addr == A_VHIGH))
      |-> (wr_data != D_KEEP))
    else $error("voltage write carried keep-default value");

  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_done) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)))
    else $error("write request dropped or changed before done");

  p_req_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && wr_done) |=> !wr_req)
    else $error("write request not released after done");

  p_bad_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bad_cmd |=> bad_cmd)
    else $error("illegal-command flag cleared");

endmodule

bind disp_pwr_seq disp_pwr_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .panel_rst (panel_rst),
  .pwr_en    (pwr_en),
  .wr_req    (wr_req),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .wr_done   (wr_done),
  .bad_cmd   (bad_cmd)
);

// File: tb/disp_pwr_seq_test.sv
module disp_pwr_seq_test;

  localparam int SUP = 40;
  localparam int RSW = 20;
  localparam int NG  = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_valid;
  logic [1:0] cmd_op;
  logic [7:0] cfg_vreg, cfg_vamp, cfg_vhigh, cfg_pol, cfg_ifctl, cfg_entry;
  logic [8*NG-1:0] cfg_gamma;
  logic panel_rst, pwr_en, wr_req, wr_done, wr_err, err_flag, bad_cmd;
  logic [7:0] wr_addr, wr_data;

  always #4 clk = ~clk;

  disp_pwr_seq #(.SUP_WAIT_CYC(SUP), .RST_WAIT_CYC(RSW), .N_GAMMA(NG)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cfg_vreg(cfg_vreg), .cfg_vamp(cfg_vamp), .cfg_vhigh(cfg_vhigh),
    .cfg_gamma(cfg_gamma), .cfg_pol(cfg_pol), .cfg_ifctl(cfg_ifctl),
    .cfg_entry(cfg_entry), .panel_rst(panel_rst), .pwr_en(pwr_en),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_done(wr_done), .wr_err(wr_err), .err_flag(err_flag), .bad_cmd(bad_cmd)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  int log_n;
  logic [7:0] log_a [0:63];
  logic [7:0] log_d [0:63];
  int inj_idx;

  int exp_n;
  logic [7:0] exp_a [0:31];
  logic [7:0] exp_d [0:31];

  int hold_cnt, hold_last, gap_cnt, gap_last;
  bit gap_arm, rise_ok, rise_seen;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // register-write port responder with random latency
  initial begin
    int lat;
    lat = -1;
    wr_done = 1'b0;
    wr_err  = 1'b0;
    forever begin
      @(negedge clk);
      if (wr_done) begin
        wr_done = 1'b0;
        wr_err  = 1'b0;
      end else if (wr_req && rst_n) begin
        if (lat < 0) lat = int'($urandom % 4);
        if (lat == 0) begin
          if (log_n < 64) begin
            log_a[log_n] = wr_addr;
            log_d[log_n] = wr_data;
          end
          wr_err  = (log_n == inj_idx);
          wr_done = 1'b1;
          log_n++;
          lat = -1;
        end else begin
          lat--;
        end
      end
    end
  end

  // pin timing monitor
  initial begin
    logic rst_prev, pwr_prev;
    rst_prev = 1'b1; pwr_prev = 1'b0;
    forever begin
      @(negedge clk);
      if (pwr_en && !pwr_prev) begin
        rise_seen = 1;
        rise_ok   = rst_prev && panel_rst;
      end
      if (pwr_en && panel_rst) hold_cnt++;
      else if (!pwr_en)        hold_cnt = 0;
      if (pwr_en && rst_prev && !panel_rst) begin
        hold_last = hold_cnt;
        hold_cnt  = 0;
        gap_arm   = 1;
        gap_cnt   = 0;
      end
      if (gap_arm) begin
        if (wr_req) begin
          gap_last = gap_cnt;
          gap_arm  = 0;
        end else begin
          gap_cnt++;
        end
      end
      rst_prev = panel_rst;
      pwr_prev = pwr_en;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    report();
  end

  function automatic void build_exp();
    exp_n = 0;
    exp_a[exp_n] = 8'h04; exp_d[exp_n] = 8'h00; exp_n++;
    if (cfg_vreg  != 8'hFF) begin exp_a[exp_n] = 8'h03; exp_d[exp_n] = cfg_vreg;  exp_n++; end
    if (cfg_vamp  != 8'hFF) begin exp_a[exp_n] = 8'h01; exp_d[exp_n] = cfg_vamp;  exp_n++; end
    if (cfg_vhigh != 8'hFF) begin exp_a[exp_n] = 8'h02; exp_d[exp_n] = cfg_vhigh; exp_n++; end
    for (int i = 0; i < NG; i++) begin
      exp_a[exp_n] = 8'h10 + 8'(i);
      exp_d[exp_n] = cfg_gamma[8*i +: 8];
      exp_n++;
    end
    exp_a[exp_n] = 8'h0A; exp_d[exp_n] = cfg_pol;   exp_n++;
    exp_a[exp_n] = 8'h0B; exp_d[exp_n] = cfg_ifctl; exp_n++;
    exp_a[exp_n] = 8'h06; exp_d[exp_n] = cfg_entry; exp_n++;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    cmd_valid = 1'b0;
    cmd_op = 2'd0;
    inj_idx = -1;
    log_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send_cmd(input logic [1:0] op);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op = op;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_writes(input int n);
    for (int i = 0; i < 3000 && log_n < n; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic rand_cfg(input bit allow_keep);
    cfg_vreg  = (allow_keep && ($urandom % 3 == 0)) ? 8'hFF : 8'($urandom % 255);
    cfg_vamp  = (allow_keep && ($urandom % 3 == 0)) ? 8'hFF : 8'($urandom % 255);
    cfg_vhigh = (allow_keep && ($urandom % 3 == 0)) ? 8'hFF : 8'($urandom % 255);
    cfg_gamma = {$urandom, $urandom};
    cfg_pol   = 8'($urandom);
    cfg_ifctl = 8'($urandom);
    cfg_entry = 8'($urandom);
  endtask

  task automatic start_prepare();
    log_n = 0;
    hold_last = -1;
    gap_last = -1;
    rise_seen = 0;
    rise_ok = 0;
    build_exp();
    send_cmd(2'd0);
  endtask

  task automatic finish_prepare(input string tag);
    wait_writes(exp_n);
    chk(rise_seen && rise_ok, {"R1 reset before supply ", tag}, int'(rise_ok), 1);
    chk(hold_last == SUP, {"R2 supply settle ", tag}, hold_last, SUP);
    chk(gap_last >= RSW && gap_last <= RSW + 2, {"R3 reset settle ", tag}, gap_last, RSW + 1);
    chk(log_n == exp_n, {"R4 R5 write count ", tag}, log_n, exp_n);
    for (int i = 0; i < exp_n && i < log_n; i++) begin
      chk(log_a[i] == exp_a[i], {"R4 write address ", tag}, int'(log_a[i]), int'(exp_a[i]));
      chk(log_d[i] == exp_d[i], {"R4 write data ", tag}, int'(log_d[i]), int'(exp_d[i]));
    end
    chk(pwr_en == 1'b1 && panel_rst == 1'b0, {"R3 powered after init ", tag}, int'({pwr_en, panel_rst}), 2);
  endtask

  task automatic pwr_write(input logic [1:0] op, input logic [7:0] exp_dat, input string tag);
    log_n = 0;
    send_cmd(op);
    wait_writes(1);
    chk(log_n == 1, {"R7 one write ", tag}, log_n, 1);
    chk(log_a[0] == 8'h07 && log_d[0] == exp_dat, {"R7 power write ", tag},
        int'({log_a[0], log_d[0]}), int'({8'h07, exp_dat}));
  endtask

  task automatic unprepare_chk(input string tag);
    logic rst_before;
    rst_before = panel_rst;
    log_n = 0;
    send_cmd(2'd3);
    repeat (6) @(negedge clk);
    chk(pwr_en == 1'b0, {"R8 supply off ", tag}, int'(pwr_en), 0);
    chk(panel_rst == rst_before, {"R8 reset unchanged ", tag}, int'(panel_rst), int'(rst_before));
    chk(log_n == 0, {"R8 no write ", tag}, log_n, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    hold_cnt = 0; gap_arm = 0; gap_cnt = 0;
    cfg_vreg = 8'h0A; cfg_vamp = 8'h16; cfg_vhigh = 8'h36;
    cfg_gamma = 64'h2756_7372_7377_5A27;
    cfg_pol = 8'h09; cfg_ifctl = 8'h0D; cfg_entry = 8'hBF;
    do_reset();

    // R11 reset state
    chk(panel_rst == 1'b1, "R11 panel_rst", int'(panel_rst), 1);
    chk(pwr_en == 1'b0 && wr_req == 1'b0, "R11 pwr_en/wr_req", int'({pwr_en, wr_req}), 0);
    chk(err_flag == 1'b0 && bad_cmd == 1'b0, "R11 flags", int'({err_flag, bad_cmd}), 0);

    // R10 enable while off
    send_cmd(2'd1);
    repeat (4) @(negedge clk);
    chk(bad_cmd == 1'b1, "R10 enable while off flagged", int'(bad_cmd), 1);
    chk(pwr_en == 1'b0 && wr_req == 1'b0 && log_n == 0, "R10 enable while off ignored",
        int'({pwr_en, wr_req}) + log_n, 0);
    do_reset();

    // directed: all trims present
    start_prepare();
    finish_prepare("all trims");
    pwr_write(2'd1, 8'hEF, "enable");
    pwr_write(2'd2, 8'hEE, "disable");
    pwr_write(2'd1, 8'hEF, "re-enable");
    unprepare_chk("from run");
    chk(bad_cmd == 1'b0, "R10 no false illegal flag", int'(bad_cmd), 0);

    // directed: all trims keep default (R5)
    cfg_vreg = 8'hFF; cfg_vamp = 8'hFF; cfg_vhigh = 8'hFF;
    start_prepare();
    finish_prepare("R5 all skipped");
    unprepare_chk("from standby");

    // random configurations
    for (int it = 0; it < 6; it++) begin
      rand_cfg(1'b1);
      start_prepare();
      finish_prepare("random");
      if ($urandom % 2 == 1) pwr_write(2'd1, 8'hEF, "random enable");
      unprepare_chk("random");
    end

    // R9 error partway through initialisation
    rand_cfg(1'b0);
    inj_idx = 5;
    start_prepare();
    for (int i = 0; i < 3000 && !(log_n > 0 && !pwr_en); i++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(pwr_en == 1'b0, "R9 supply dropped on error", int'(pwr_en), 0);
    chk(err_flag == 1'b1, "R9 error flag set", int'(err_flag), 1);
    chk(log_n == 6, "R9 list stopped at error", log_n, 6);
    inj_idx = -1;
    start_prepare();
    repeat (3) @(negedge clk);
    chk(err_flag == 1'b0, "R9 error flag cleared by prepare", int'(err_flag), 0);
    finish_prepare("after error");

    // R9 error on enable write keeps standby
    log_n = 0;
    inj_idx = 0;
    send_cmd(2'd1);
    wait_writes(1);
    inj_idx = -1;
    chk(err_flag == 1'b1, "R9 enable error flag", int'(err_flag), 1);
    pwr_write(2'd1, 8'hEF, "R9 enable retried from standby");
    pwr_write(2'd2, 8'hEE, "R9 disable after retry");
    chk(bad_cmd == 1'b0, "R9 retry was legal", int'(bad_cmd), 0);

    // R10 disable in standby ignored
    log_n = 0;
    send_cmd(2'd2);
    repeat (8) @(negedge clk);
    chk(bad_cmd == 1'b1, "R10 disable in standby flagged", int'(bad_cmd), 1);
    chk(log_n == 0 && pwr_en == 1'b1, "R10 disable in standby ignored", log_n, 0);
    unprepare_chk("after illegal");

    // R10 command during power-up sequence
    do_reset();
    rand_cfg(1'b1);
    start_prepare();
    repeat (5) @(negedge clk);
    send_cmd(2'd3);
    repeat (2) @(negedge clk);
    chk(bad_cmd == 1'b1, "R10 unprepare during sequence flagged", int'(bad_cmd), 1);
    chk(pwr_en == 1'b1, "R10 unprepare during sequence ignored", int'(pwr_en), 1);
    finish_prepare("R10 busy command");
    send_cmd(2'd0);
    repeat (4) @(negedge clk);
    chk(bad_cmd == 1'b1 && wr_req == 1'b0, "R10 prepare while prepared ignored",
        int'({bad_cmd, wr_req}), 2);

    repeat (5) @(negedge clk);
    report();
  end

endmodule